// File: doc/BRIEF.md
# Trap and Interrupt State Unit

This block is a single-stage execution unit for a 64-bit core. It takes one operation per handshake and computes everything that changes control flow or machine state. The operations are conditional trap compares in doubleword and word widths, each in register and immediate forms, writes and reads of the machine state register (MSR), system call, and return from interrupt. It produces an integer result, new values for the two save/restore registers (SRR0 holds the return address, SRR1 holds the saved state), the next instruction address and the new MSR.

Every interrupt goes through one shared entry path. This covers a taken trap, a system call, a privilege violation, and an interrupt injected from outside through the `in_irq` input. MSR bits are split into full-function bits and partial-function bits. Only the full-function bits are saved into SRR1 and restored from it; the partial-function bits keep their current values.

The control is a two-state machine. In state `S_IDLE` the unit is ready. Transition *accept* (`in_valid` while in `S_IDLE`) registers the result and moves to `S_HOLD`. In `S_HOLD` the outputs are valid and held. Transition *drain* (`out_ready` while in `S_HOLD`) returns to `S_IDLE`. Reset enters `S_IDLE`.

Top module: `trap_unit`

## Requirements
- R1: In `S_IDLE` `in_ready` is 1. An operation accepted at a clock edge shows `out_valid`=1 and `in_ready`=0 after that edge. All outputs stay unchanged until a cycle with `out_ready`=1, after which `in_ready` returns to 1.
- R2: After reset `out_valid` is 0 and `in_ready` is 1.
- R3: Doubleword traps (op 0 register form, op 2 immediate form) compare A with B. The 5-bit TO field enables these conditions: bit 4 signed less, bit 3 signed greater, bit 2 equal, bit 1 unsigned less, bit 0 unsigned greater. A trap is taken when any enabled condition holds.
- R4: Word traps (op 1, op 3) apply the R3 conditions to the low 32 bits only. Signed tests sign-extend those bits and unsigned tests zero-extend them. Immediate forms use the `IMM_W`-bit immediate, sign-extended, as B.
- R5: A taken trap gives next address `PROG_VEC`, SRR0 = PC, and SRR1 = (MSR AND full mask) OR bit 17, with `out_srr_we`=1. A trap that is not taken gives next address PC+4, MSR unchanged and `out_srr_we`=0. The full mask is 0xFFFFFFFF87C0FFFF, little-endian numbering.
- R6: On every interrupt entry the new MSR equals the old MSR with bit 63 (64-bit mode) set and bits 15 (external enable), 14 (problem state), 5 and 4 (relocation) cleared.
- R7: System call (op 6) gives next address `SYSCALL_VEC`, SRR0 = PC+4 and SRR1 = MSR AND full mask.
- R8: Return from interrupt (op 7) gives next address = SRR0 with bits 1:0 cleared. The new MSR takes its full-function bits from SRR1 and keeps its partial-function bits from the current MSR.
- R9: MSR write (op 4) takes the full-function bits from A, keeps the partial-function bits, and gives next address PC+4.
- R10: MSR read (op 5) returns the MSR on `out_result`. Every other operation returns 0.
- R11: If op 4 or op 7 arrives while MSR bit 14 is 1, a program interrupt is taken instead. The next address is `PROG_VEC`, SRR0 = PC, and SRR1 = (MSR AND full mask) OR bit 18. The requested MSR change is not made; the R6 entry rules apply.
- R12: With `in_irq`=1 the operation is ignored. An interrupt is entered with next address `in_irq_vec`, SRR0 = PC and SRR1 = MSR AND full mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept |
| in_op | input | 3 | Operation code (0 td, 1 tw, 2 tdi, 3 twi, 4 MSR write, 5 MSR read, 6 system call, 7 return) |
| in_to | input | 5 | Trap condition enables |
| in_imm | input | IMM_W | Immediate for trap immediate forms |
| in_irq | input | 1 | Inject external interrupt |
| in_irq_vec | input | 64 | Vector for injected interrupt |
| in_ra | input | 64 | Operand A |
| in_rb | input | 64 | Operand B |
| in_srr0 | input | 64 | Current SRR0 |
| in_srr1 | input | 64 | Current SRR1 |
| in_msr | input | 64 | Current MSR |
| in_pc | input | 64 | Address of this operation |
| out_valid | output | 1 | Results valid |
| out_ready | input | 1 | Consumer takes results |
| out_result | output | 64 | Integer result |
| out_srr0 | output | 64 | New SRR0 |
| out_srr1 | output | 64 | New SRR1 |
| out_srr_we | output | 1 | Write both SRRs |
| out_nia | output | 64 | Next instruction address |
| out_msr | output | 64 | New MSR |

## Verification
The bench builds the unit with its default parameters: `IMM_W`=16, `PROG_VEC`=0x700 and `SYSCALL_VEC`=0xC00. With a 16-bit immediate, values 0x8000 and up reach the sign-extension path of both the word and doubleword immediate traps. The two distinct vectors let the bench tell trap entries apart from system-call entries. Random MSR values set the problem-state bit about half the time, so the privilege path and the partial-bit preservation in return and MSR write are each exercised many times.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN = 64;

    typedef enum logic [2:0] {
        OP_TD    = 3'd0,
        OP_TW    = 3'd1,
        OP_TDI   = 3'd2,
        OP_TWI   = 3'd3,
        OP_MTMSR = 3'd4,
        OP_MFMSR = 3'd5,
        OP_SC    = 3'd6,
        OP_RFID  = 3'd7
    } trap_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } unit_state_e;

    // Map an MSB-first bit index to little-endian position.
    function automatic int le_pos(input int msb_idx);
        return XLEN - 1 - msb_idx;
    endfunction

    function automatic logic [XLEN-1:0] msb_span(input int first, input int last);
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = first; i <= last; i++) m[le_pos(i)] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] MSR_FULL =
        msb_span(0, 32) | msb_span(37, 41) | msb_span(48, 63);
    localparam logic [XLEN-1:0] MSR_PART = ~MSR_FULL;

    localparam int MSR_SF    = le_pos(0);
    localparam int MSR_EE    = le_pos(48);
    localparam int MSR_PR    = le_pos(49);
    localparam int MSR_IR    = le_pos(58);
    localparam int MSR_DR    = le_pos(59);
    localparam int SRR1_PRIV = le_pos(45);
    localparam int SRR1_TRAP = le_pos(46);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] nia;
        logic [XLEN-1:0] msr;
        logic            srr_we;
    } trap_res_t;
endpackage

// File: rtl/trap_cond_eval.sv
module trap_cond_eval #(
    parameter int XW = 64
) (
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    input  logic          word,
    input  logic [4:0]    to,
    output logic          take
);
    logic [XW-1:0] a_s, b_s, a_u, b_u;
    logic slt, sgt, eq, ult, ugt;

    always_comb begin
        if (word) begin
            a_s = {{(XW-32){a[31]}}, a[31:0]};
            b_s = {{(XW-32){b[31]}}, b[31:0]};
            a_u = {{(XW-32){1'b0}}, a[31:0]};
            b_u = {{(XW-32){1'b0}}, b[31:0]};
        end else begin
            a_s = a;
            b_s = b;
            a_u = a;
            b_u = b;
        end
        slt  = $signed(a_s) < $signed(b_s);
        sgt  = $signed(a_s) > $signed(b_s);
        eq   = a_u == b_u;
        ult  = a_u < b_u;
        ugt  = a_u > b_u;
        take = |(to & {slt, sgt, eq, ult, ugt});
    end
endmodule

// File: rtl/trap_msr_merge.sv
module trap_msr_merge #(
    parameter int             XW   = 64,
    parameter logic [XW-1:0]  MASK = '0
) (
    input  logic [XW-1:0] keep,
    input  logic [XW-1:0] src,
    output logic [XW-1:0] merged
);
    for (genvar i = 0; i < XW; i++) begin : g_bit
        if (MASK[i]) begin : g_take
            assign merged[i] = src[i];
        end else begin : g_keep
            assign merged[i] = keep[i];
        end
    end
endmodule

// File: rtl/trap_exec_logic.sv
module trap_exec_logic
    import trap_pkg::*;
#(
    parameter int              IMM_W       = 16,
    parameter logic [XLEN-1:0] PROG_VEC    = 64'h700,
    parameter logic [XLEN-1:0] SYSCALL_VEC = 64'hC00,
    parameter int              INSN_BYTES  = 4
) (
    input  logic [2:0]       op,
    input  logic [4:0]       to,
    input  logic [IMM_W-1:0] imm,
    input  logic             irq,
    input  logic [XLEN-1:0]  irq_vec,
    input  logic [XLEN-1:0]  ra,
    input  logic [XLEN-1:0]  rb,
    input  logic [XLEN-1:0]  srr0,
    input  logic [XLEN-1:0]  srr1,
    input  logic [XLEN-1:0]  msr,
    input  logic [XLEN-1:0]  pc,
    output trap_res_t        res
);
    trap_op_e        op_e;
    logic [XLEN-1:0] opnd_b, imm_ext, pc_next;
    logic            is_word, is_imm, take;
    logic [XLEN-1:0] rfid_msr, mt_msr;
    logic            enter, priv_fault;
    logic [XLEN-1:0] vec, ret_addr, reason, entry_msr;

    assign op_e    = trap_op_e'(op);
    assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign is_word = (op_e == OP_TW) || (op_e == OP_TWI);
    assign is_imm  = (op_e == OP_TDI) || (op_e == OP_TWI);
    assign opnd_b  = is_imm ? imm_ext : rb;
    assign pc_next = pc + XLEN'(INSN_BYTES);

    trap_cond_eval #(.XW(XLEN)) u_cond (
        .a(ra), .b(opnd_b), .word(is_word), .to(to), .take(take)
    );

    trap_msr_merge #(.XW(XLEN), .MASK(MSR_FULL)) u_rfid_merge (
        .keep(msr), .src(srr1), .merged(rfid_msr)
    );

    trap_msr_merge #(.XW(XLEN), .MASK(MSR_FULL)) u_mt_merge (
        .keep(msr), .src(ra), .merged(mt_msr)
    );

    always_comb begin
        entry_msr         = msr;
        entry_msr[MSR_SF] = 1'b1;
        entry_msr[MSR_EE] = 1'b0;
        entry_msr[MSR_PR] = 1'b0;
        entry_msr[MSR_IR] = 1'b0;
        entry_msr[MSR_DR] = 1'b0;
    end

    assign priv_fault = ((op_e == OP_MTMSR) || (op_e == OP_RFID)) && msr[MSR_PR];

    always_comb begin
        res        = '0;
        res.srr0   = srr0;
        res.srr1   = srr1;
        res.nia    = pc_next;
        res.msr    = msr;
        enter      = 1'b0;
        vec        = '0;
        ret_addr   = pc;
        reason     = '0;
        if (irq) begin
            enter = 1'b1;
            vec   = irq_vec;
        end else if (priv_fault) begin
            enter             = 1'b1;
            vec               = PROG_VEC;
            reason[SRR1_PRIV] = 1'b1;
        end else begin
            unique case (op_e)
                OP_TD, OP_TW, OP_TDI, OP_TWI: begin
                    if (take) begin
                        enter             = 1'b1;
                        vec               = PROG_VEC;
                        reason[SRR1_TRAP] = 1'b1;
                    end
                end
                OP_MTMSR: res.msr    = mt_msr;
                OP_MFMSR: res.result = msr;
                OP_SC: begin
                    enter    = 1'b1;
                    vec      = SYSCALL_VEC;
                    ret_addr = pc_next;
                end
                OP_RFID: begin
                    res.nia = {srr0[XLEN-1:2], 2'b00};
                    res.msr = rfid_msr;
                end
                default: ;
            endcase
        end
        if (enter) begin
            res.srr_we = 1'b1;
            res.srr0   = ret_addr;
            res.srr1   = (msr & MSR_FULL) | reason;
            res.nia    = vec;
            res.msr    = entry_msr;
        end
    end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int          IMM_W       = 16,
    parameter logic [63:0] PROG_VEC    = 64'h700,
    parameter logic [63:0] SYSCALL_VEC = 64'hC00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_op,
    input  logic [4:0]       in_to,
    input  logic [IMM_W-1:0] in_imm,
    input  logic             in_irq,
    input  logic [63:0]      in_irq_vec,
    input  logic [63:0]      in_ra,
    input  logic [63:0]      in_rb,
    input  logic [63:0]      in_srr0,
    input  logic [63:0]      in_srr1,
    input  logic [63:0]      in_msr,
    input  logic [63:0]      in_pc,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_result,
    output logic [63:0]      out_srr0,
    output logic [63:0]      out_srr1,
    output logic             out_srr_we,
    output logic [63:0]      out_nia,
    output logic [63:0]      out_msr
);
    unit_state_e state_q, state_d;
    trap_res_t   comb_res, res_q;
    logic        accept;

    trap_exec_logic #(
        .IMM_W(IMM_W), .PROG_VEC(PROG_VEC), .SYSCALL_VEC(SYSCALL_VEC), .INSN_BYTES(4)
    ) u_exec (
        .op(in_op), .to(in_to), .imm(in_imm), .irq(in_irq), .irq_vec(in_irq_vec),
        .ra(in_ra), .rb(in_rb), .srr0(in_srr0), .srr1(in_srr1),
        .msr(in_msr), .pc(in_pc), .res(comb_res)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept (S_IDLE -> S_HOLD), drain (S_HOLD -> S_IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid)  state_d = S_HOLD;
            S_HOLD: if (out_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            S_IDLE: in_ready  = 1'b1;
            S_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (accept) res_q <= comb_res;
    end

    assign out_result = res_q.result;
    assign out_srr0   = res_q.srr0;
    assign out_srr1   = res_q.srr1;
    assign out_srr_we = res_q.srr_we;
    assign out_nia    = res_q.nia;
    assign out_msr    = res_q.msr;
endmodule

// File: rtl/trap_unit_checker.sv
module trap_unit_checker
    import trap_pkg::*;
#(
    parameter int          IMM_W    = 16,
    parameter logic [63:0] PROG_VEC = 64'h700
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_op,
    input logic             in_irq,
    input logic [63:0]      in_irq_vec,
    input logic [63:0]      in_msr,
    input logic [63:0]      in_pc,
    input logic             out_valid,
    input logic             out_ready,
    input logic [63:0]      out_srr0,
    input logic [63:0]      out_srr1,
    input logic             out_srr_we,
    input logic [63:0]      out_nia,
    input logic [63:0]      out_msr
);
    logic acc;
    assign acc = in_valid && in_ready;

    assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_accept_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_nia)
            && $stable(out_msr) && $stable(out_srr1) && $stable(out_srr0)));

    assert_entry_msr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_srr_we) |-> (out_msr[MSR_SF] && !out_msr[MSR_EE]
            && !out_msr[MSR_PR] && !out_msr[MSR_IR] && !out_msr[MSR_DR]));

    assert_rfid_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_irq && in_op == 3'd7 && !in_msr[MSR_PR])
            |=> (((out_msr ^ $past(in_msr)) & MSR_PART) == '0));

    assert_priv_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_irq && (in_op == 3'd4 || in_op == 3'd7) && in_msr[MSR_PR])
            |=> (out_srr_we && out_srr1[SRR1_PRIV] && out_nia == PROG_VEC));

    assert_irq_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_irq) |=> (out_nia == $past(in_irq_vec)
            && out_srr0 == $past(in_pc) && out_srr_we));
endmodule

bind trap_unit trap_unit_checker #(.IMM_W(IMM_W), .PROG_VEC(PROG_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_irq(in_irq), .in_irq_vec(in_irq_vec), .in_msr(in_msr),
    .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
    .out_srr0(out_srr0), .out_srr1(out_srr1), .out_srr_we(out_srr_we),
    .out_nia(out_nia), .out_msr(out_msr)
);

// File: tb/trap_unit_bench.sv
`timescale 1ns/100ps
module trap_unit_bench;
    localparam logic [63:0] FULL  = 64'hFFFF_FFFF_87C0_FFFF;
    localparam logic [63:0] PVEC  = 64'h700;
    localparam logic [63:0] SCVEC = 64'hC00;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0, in_irq = 1'b0;
    logic in_ready, out_valid, out_srr_we;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_to = '0;
    logic [15:0] in_imm = '0;
    logic [63:0] in_irq_vec = '0, in_ra = '0, in_rb = '0, in_srr0 = '0;
    logic [63:0] in_srr1 = '0, in_msr = '0, in_pc = '0;
    logic [63:0] out_result, out_srr0, out_srr1, out_nia, out_msr;
    int errors = 0, checks = 0, cycles = 0;

    always #2.5 clk = ~clk;

    trap_unit u_trap_unit (.*);

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic signed [64:0] sx(input logic [63:0] v, input bit w, input bit sgn);
        if (w) return sgn ? {{33{v[31]}}, v[31:0]} : {33'd0, v[31:0]};
        return sgn ? {v[63], v} : {1'b0, v};
    endfunction

    function automatic bit cond_hit(input logic [4:0] to, input logic [63:0] a,
                                    input logic [63:0] b, input bit w);
        bit hit = 0;
        if (to[4] && sx(a, w, 1) < sx(b, w, 1)) hit = 1;
        if (to[3] && sx(a, w, 1) > sx(b, w, 1)) hit = 1;
        if (to[2] && sx(a, w, 0) == sx(b, w, 0)) hit = 1;
        if (to[1] && sx(a, w, 0) < sx(b, w, 0)) hit = 1;
        if (to[0] && sx(a, w, 0) > sx(b, w, 0)) hit = 1;
        return hit;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [4:0] to, input logic [15:0] imm,
                          input bit irq, input logic [63:0] vec, input logic [63:0] ra,
                          input logic [63:0] rb, input logic [63:0] s0, input logic [63:0] s1,
                          input logic [63:0] msr, input logic [63:0] pc);
        logic [63:0] e_res, e_s0, e_s1, e_nia, e_msr, bval, ent;
        bit e_we, enter, prv;
        string tag;
        e_res = 0; e_s0 = s0; e_s1 = s1; e_nia = pc + 4; e_msr = msr; e_we = 0; enter = 0;
        prv = (op == 3'd4 || op == 3'd7) && msr[14];
        case (op)
            3'd0, 3'd2: tag = "R3";
            3'd1, 3'd3: tag = "R4";
            3'd4: tag = "R9";
            3'd5: tag = "R10";
            3'd6: tag = "R7";
            default: tag = "R8";
        endcase
        if (irq) tag = "R12"; else if (prv) tag = "R11";
        ent = msr; ent[63] = 1; ent[15] = 0; ent[14] = 0; ent[5] = 0; ent[4] = 0;
        if (irq) begin
            enter = 1; e_nia = vec; e_s0 = pc; e_s1 = msr & FULL;
        end else if (prv) begin
            enter = 1; e_nia = PVEC; e_s0 = pc; e_s1 = (msr & FULL) | (64'd1 << 18);
        end else if (op <= 3'd3) begin
            bval = op[1] ? {{48{imm[15]}}, imm} : rb;
            if (cond_hit(to, ra, bval, op[0])) begin
                enter = 1; e_nia = PVEC; e_s0 = pc; e_s1 = (msr & FULL) | (64'd1 << 17);
                tag = (tag == "R3") ? "R3/R5" : "R4/R5";
            end
        end else if (op == 3'd4) e_msr = (ra & FULL) | (msr & ~FULL);
        else if (op == 3'd5) e_res = msr;
        else if (op == 3'd6) begin
            enter = 1; e_nia = SCVEC; e_s0 = pc + 4; e_s1 = msr & FULL;
        end else begin
            e_nia = {s0[63:2], 2'b00}; e_msr = (s1 & FULL) | (msr & ~FULL);
        end
        if (enter) begin e_we = 1; e_msr = ent; end

        in_op = op; in_to = to; in_imm = imm; in_irq = irq; in_irq_vec = vec;
        in_ra = ra; in_rb = rb; in_srr0 = s0; in_srr1 = s1; in_msr = msr; in_pc = pc;
        in_valid = 1;
        @(posedge clk); #1;
        in_valid = 0;
        chk(out_valid && !in_ready, "R1", "valid/ready", {62'd0, out_valid, in_ready}, 64'd2);
        chk(out_nia == e_nia, tag, "nia", out_nia, e_nia);
        chk(out_msr == e_msr, enter ? {tag, "/R6"} : tag, "msr", out_msr, e_msr);
        chk(out_srr_we == e_we, tag, "srr_we", {63'd0, out_srr_we}, {63'd0, e_we});
        if (e_we) begin
            chk(out_srr0 == e_s0, tag, "srr0", out_srr0, e_s0);
            chk(out_srr1 == e_s1, tag, "srr1", out_srr1, e_s1);
        end
        chk(out_result == e_res, {tag, "/R10"}, "result", out_result, e_res);
        out_ready = 1;
        @(posedge clk); #1;
        out_ready = 0;
        chk(in_ready && !out_valid, "R1", "drain", {62'd0, out_valid, in_ready}, 64'd1);
    endtask

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk(!out_valid && in_ready, "R2", "reset state", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1;
        @(posedge clk); #1;

        // Directed corner cases
        run_op(3'd0, 5'b00100, 0, 0, 0, 64'd5, 64'd5, 0, 0, 64'h8000_0000_0000_0000, 64'h1000); // R3 eq
        run_op(3'd0, 5'b10000, 0, 0, 0, '1, 64'd1, 0, 0, 0, 64'h1004);  // R3 signed less taken
        run_op(3'd0, 5'b00010, 0, 0, 0, '1, 64'd1, 0, 0, 0, 64'h1008);  // R3 unsigned less not taken
        run_op(3'd0, 5'b00000, 0, 0, 0, 64'd3, 64'd3, 0, 0, 0, 64'h100C); // R3 no condition
        run_op(3'd1, 5'b00100, 0, 0, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678,
               0, 0, 0, 64'h1010);                                       // R4 low word equal
        run_op(3'd3, 5'b00100, 16'hFFFF, 0, 0, 64'h0000_0000_FFFF_FFFF, 0, 0, 0, 0, 64'h1014); // R4 imm sign
        run_op(3'd2, 5'b00001, 16'h8000, 0, 0, 64'd1, 0, 0, 0, 0, 64'h1018);  // R4 tdi unsigned greater? no
        run_op(3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2000);      // R7
        run_op(3'd7, 0, 0, 0, 0, 0, 0, 64'h3003, 64'h0, 64'h0000_0000_783F_0000, 64'h2004); // R8
        run_op(3'd4, 0, 0, 0, 0, '1, 0, 0, 0, 0, 64'h2008);                  // R9
        run_op(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 64'h4000, 64'h200C);            // R11
        run_op(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'h2010); // R10
        run_op(3'd6, 0, 0, 1, 64'h500, 0, 0, 0, 0, 64'h8020, 64'h2014);      // R12 beats syscall

        // R1 backpressure: outputs held while out_ready low
        in_op = 3'd6; in_irq = 0; in_pc = 64'h4000; in_msr = 0; in_valid = 1;
        @(posedge clk); #1;
        in_valid = 0;
        held = out_nia;
        repeat (3) begin
            @(posedge clk); #1;
            chk(out_valid && !in_ready && out_nia == held, "R1", "hold nia", out_nia, held);
        end
        out_ready = 1;
        @(posedge clk); #1;
        out_ready = 0;

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [63:0] a, b;
            op = 3'($urandom_range(0, 7));
            a = {$urandom, $urandom};
            b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) b[31:0] = a[31:0];
            run_op(op, 5'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0),
                   {$urandom, $urandom}, a, b, {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom});
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule